// File: doc/BRIEF.md
# Signed Two's-Complement Array Multiplier

This block multiplies two signed operands of `N` bits (default 5) and returns the full 2N-bit signed product. It never subtracts and never sign-extends. The negatively weighted bits that a two's-complement multiply produces are rewritten as inverted or gated bits plus fixed correction constants, so that every entry of the partial-product matrix adds with positive weight. A chain of carry-save rows made of one kind of full-adder cell then sums the matrix. A ripple adder resolves the last sum/carry pair, and any carry beyond the top bit is dropped.

The parameter `ARR` chooses between two matrix layouts. Both give the same product:

- **Conventional layout (`BW_CONV`).** The sign row of B is gated by b's sign bit, and a b-sign entry sits in column N-1. The tallest column is 7 entries at N = 5, and the layout needs N+2 rows.
- **Modified layout (`BW_MOD`).** Both cross rows are plain inverted AND terms, and the corrections are folded into two constant bits. The tallest column is 5 entries at N = 5, and the layout needs only N+1 rows.

The parameter `REG_OUT` adds one output register so that the datapath can sit between flops for timing work. With `REG_OUT` = 0 the block is purely combinational.

Top module: `bw_mult_top`

## Requirements
- R1: `prod` equals the signed product of `op_a` and `op_b` taken modulo 2^(2N). With `REG_OUT` = 1 it appears one rising clock edge after the operands are sampled.
- R2: The most negative operand squared, -16 × -16 at N = 5, gives +256 (`prod` = 10'h100) with no overflow.
- R3: When either operand is zero, `prod` is zero.
- R4: The conventional and modified layouts give identical products for all 1024 operand pairs at N = 5.
- R5: While `rst` is high, and on the first output after it, a registered `prod` reads zero, whatever the operands are.
- R6: For nonzero operands, `prod` bit 2N-1 is 1 exactly when the operand sign bits (bit N-1) differ.
- R7: Swapping `op_a` and `op_b` leaves `prod` unchanged.
- R8: -16 × 15 and 15 × -16 both give -240 (10'h310).
- R9: With `REG_OUT` = 0, `prod` follows the operands combinationally within the same cycle.
- R10: While the operands are held constant, a registered `prod` holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | N | Signed multiplicand, two's complement |
| op_b | input | N | Signed multiplier, two's complement |
| prod | output | 2N | Signed full-precision product |

## Verification
For registered instances, each product is due at the first rising edge after the operands are applied. The bench changes the operands on a falling edge and reads the registered instances on the next falling edge, which sits half a period after the register loads. The combinational instance is read 1 ns after the operands change, inside the same low phase, so no reading depends on event order at a rising edge. The hold and reset checks also read on falling edges, several cycles in a row, so that every value is compared against a full cycle of settled state.

// File: rtl/bw_pkg.sv
package bw_pkg;

    // Matrix layout selector
    typedef enum logic {
        BW_CONV = 1'b0,
        BW_MOD  = 1'b1
    } bw_arr_e;

    // Number of partial-product rows each layout produces
    function automatic int bw_rows(input int n, input bw_arr_e arr);
        return (arr == BW_CONV) ? n + 2 : n + 1;
    endfunction

    // Height of the tallest column, used to document the layouts
    function automatic int bw_peak_height(input int n, input bw_arr_e arr);
        return (arr == BW_CONV) ? n + 2 : n;
    endfunction

endpackage

// File: rtl/bw_fa.sv
module bw_fa (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic co
);
    assign s  = x ^ y ^ z;
    assign co = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/bw_pp_matrix.sv
module bw_pp_matrix
    import bw_pkg::*;
#(
    parameter int      N   = 5,
    parameter bw_arr_e ARR = BW_MOD
) (
    input  logic [N-1:0]                         op_a,
    input  logic [N-1:0]                         op_b,
    output logic [bw_rows(N, ARR)-1:0][2*N-1:0]  rows
);
    localparam int W2   = 2 * N;
    localparam int ROWS = bw_rows(N, ARR);

    // Row for multiplier bit j (j < N-1): magnitude bits plus inverted sign term
    function automatic logic [W2-1:0] mag_row(input logic [N-1:0] a, input logic bj, input int j);
        logic [W2-1:0] r;
        r = '0;
        for (int i = 0; i < N - 1; i++) r[i+j] = a[i] & bj;
        r[N-1+j] = ~(a[N-1] & bj);
        return r;
    endfunction

    if (ARR == BW_MOD) begin : g_mod
        always_comb begin
            rows = '0;
            for (int j = 0; j < N - 1; j++) rows[j] = mag_row(op_a, op_b[j], j);
            for (int i = 0; i < N - 1; i++) rows[N-1][N-1+i] = ~(op_b[N-1] & op_a[i]);
            rows[N-1][W2-2] = op_a[N-1] & op_b[N-1];
            rows[N][N]      = 1'b1;
            rows[N][W2-1]   = 1'b1;
        end
    end else begin : g_conv
        always_comb begin
            rows = '0;
            for (int j = 0; j < N - 1; j++) rows[j] = mag_row(op_a, op_b[j], j);
            // two's complement of A's low bits, added when b's sign is set
            for (int i = 0; i < N - 1; i++) rows[N-1][N-1+i] = op_b[N-1] & ~op_a[i];
            rows[N][N-1]    = 1'b1;
            rows[N][W2-2]   = 1'b1;
            rows[N][W2-1]   = 1'b1;
            rows[N+1][N-1]  = op_b[N-1];
            rows[N+1][W2-2] = ~op_a[N-1] & op_b[N-1];
            rows[N+1][W2-1] = ~op_a[N-1] & op_b[N-1];
        end
    end

    if (ROWS < 3) begin : g_bad_rows
        initial $error("bw_pp_matrix: N too small");
    end
endmodule

// File: rtl/bw_csa_array.sv
module bw_csa_array #(
    parameter int W    = 10,
    parameter int ROWS = 6
) (
    input  logic [ROWS-1:0][W-1:0] rows,
    output logic [W-1:0]           sum_v,
    output logic [W-1:0]           car_v
);
    logic [ROWS-1:1][W-1:0] st_s;
    logic [ROWS-1:1][W-1:0] st_c;

    assign st_s[1] = rows[0];
    assign st_c[1] = rows[1];

    for (genvar k = 2; k < ROWS; k++) begin : g_stage
        logic [W-2:0] co;
        for (genvar b = 0; b < W - 1; b++) begin : g_cell
            bw_fa u_fa (
                .x (st_s[k-1][b]),
                .y (st_c[k-1][b]),
                .z (rows[k][b]),
                .s (st_s[k][b]),
                .co(co[b])
            );
        end
        // top column: carry would leave the 2N-bit result, keep only the sum
        assign st_s[k][W-1] = st_s[k-1][W-1] ^ st_c[k-1][W-1] ^ rows[k][W-1];
        assign st_c[k]      = {co, 1'b0};
    end

    assign sum_v = st_s[ROWS-1];
    assign car_v = st_c[ROWS-1];
endmodule

// File: rtl/bw_ripple_cpa.sv
module bw_ripple_cpa #(
    parameter int W = 10
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    logic [W-1:0] cy;
    assign cy[0] = 1'b0;

    for (genvar b = 0; b < W - 1; b++) begin : g_bit
        bw_fa u_fa (
            .x (x[b]),
            .y (y[b]),
            .z (cy[b]),
            .s (sum[b]),
            .co(cy[b+1])
        );
    end
    assign sum[W-1] = x[W-1] ^ y[W-1] ^ cy[W-1];
endmodule

// File: rtl/bw_mult_top.sv
module bw_mult_top
    import bw_pkg::*;
#(
    parameter int      N       = 5,
    parameter bw_arr_e ARR     = BW_MOD,
    parameter bit      REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] prod
);
    localparam int W2   = 2 * N;
    localparam int ROWS = bw_rows(N, ARR);

    logic [ROWS-1:0][W2-1:0] pp_rows;
    logic [W2-1:0]           cs_sum;
    logic [W2-1:0]           cs_car;
    logic [W2-1:0]           sum_c;

    bw_pp_matrix #(.N(N), .ARR(ARR)) u_matrix (
        .op_a(op_a),
        .op_b(op_b),
        .rows(pp_rows)
    );

    bw_csa_array #(.W(W2), .ROWS(ROWS)) u_csa (
        .rows (pp_rows),
        .sum_v(cs_sum),
        .car_v(cs_car)
    );

    bw_ripple_cpa #(.W(W2)) u_cpa (
        .x  (cs_sum),
        .y  (cs_car),
        .sum(sum_c)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) prod <= '0;
            else     prod <= sum_c;
        end
    end else begin : g_comb
        assign prod = sum_c;
    end
endmodule

// File: rtl/bw_mult_chk.sv
module bw_mult_chk #(
    parameter int N       = 5,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic [2*N-1:0] prod
);
    localparam int W2 = 2 * N;

    if (REG_OUT) begin : g_chk
        logic signed [W2-1:0] ref_c;
        logic [1:0]           primed;

        assign ref_c = $signed(op_a) * $signed(op_b);

        always_ff @(posedge clk) begin
            if (rst) primed <= 2'b00;
            else     primed <= {primed[0], 1'b1};
        end

        // R1: registered result matches signed product of sampled operands
        p_product_r1: assert property (@(posedge clk) disable iff (rst)
            primed[0] |-> prod == $past(ref_c));

        // R3: zero operand gives zero
        p_zero_r3: assert property (@(posedge clk) disable iff (rst)
            primed[0] && ($past(op_a) == '0 || $past(op_b) == '0) |-> prod == '0);

        // R6: sign of result for nonzero operands
        p_sign_r6: assert property (@(posedge clk) disable iff (rst)
            primed[0] && $past(op_a) != '0 && $past(op_b) != '0
            |-> prod[W2-1] == ($past(op_a[N-1]) ^ $past(op_b[N-1])));

        // R5: output cleared after a reset cycle
        p_reset_r5: assert property (@(posedge clk)
            $past(rst) |-> prod == '0);

        // R10: constant operands keep the output constant
        p_hold_r10: assert property (@(posedge clk) disable iff (rst)
            primed[1] && $past($stable(op_a)) && $past($stable(op_b)) |-> $stable(prod));
    end
endmodule

bind bw_mult_top bw_mult_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk (clk),
    .rst (rst),
    .op_a(op_a),
    .op_b(op_b),
    .prod(prod)
);

// File: tb/tb_bw_mult_top.sv
module tb_bw_mult_top;
    import bw_pkg::*;

    localparam int N  = 5;
    localparam int W2 = 2 * N;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  op_a = '0;
    logic [N-1:0]  op_b = '0;
    logic [W2-1:0] p_conv, p_mod, p_comb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bw_mult_top #(.N(N), .ARR(BW_CONV), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod(p_conv));
    bw_mult_top #(.N(N), .ARR(BW_MOD), .REG_OUT(1'b1)) dut_mod (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod(p_mod));
    bw_mult_top #(.N(N), .ARR(BW_MOD), .REG_OUT(1'b0)) dut_comb (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod(p_comb));

    function automatic logic [W2-1:0] exp_prod(input int sa, input int sb);
        int e;
        e = sa * sb;
        return e[W2-1:0];
    endfunction

    task automatic chk(input string req, input logic [W2-1:0] got, input logic [W2-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%h expected=%h", req, got, exp);
        end
    endtask

    // drive at a falling edge; comb read 1 ns later, registered read one cycle later
    task automatic apply(input int sa, input int sb,
                         output logic [W2-1:0] rc, output logic [W2-1:0] rm,
                         output logic [W2-1:0] rb);
        @(negedge clk);
        op_a = sa[N-1:0];
        op_b = sb[N-1:0];
        #1 rb = p_comb;
        @(negedge clk);
        rc = p_conv;
        rm = p_mod;
    endtask

    task automatic t_reset;
        @(negedge clk);
        op_a = 5'b10110;
        op_b = 5'b01011;
        @(negedge clk);
        chk("R5 conv in reset", p_conv, '0);
        chk("R5 mod in reset", p_mod, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_exhaustive;
        logic [W2-1:0] rc, rm, rb, e;
        for (int sa = -16; sa < 16; sa++) begin
            for (int sb = -16; sb < 16; sb++) begin
                apply(sa, sb, rc, rm, rb);
                e = exp_prod(sa, sb);
                chk("R1 conv", rc, e);
                chk("R4 conv vs mod", rm, rc);
                chk("R9 comb", rb, e);
                if (sa != 0 && sb != 0)
                    chk("R6 sign", {9'd0, rm[W2-1]}, {9'd0, (sa < 0) != (sb < 0)});
            end
        end
    endtask

    task automatic t_corners;
        logic [W2-1:0] rc, rm, rb;
        apply(-16, -16, rc, rm, rb);
        chk("R2 conv", rc, 10'h100);
        chk("R2 mod", rm, 10'h100);
        apply(-16, 15, rc, rm, rb);
        chk("R8 conv", rc, 10'h310);
        chk("R8 mod", rm, 10'h310);
        apply(15, -16, rc, rm, rb);
        chk("R8 swapped", rm, 10'h310);
        apply(0, -11, rc, rm, rb);
        chk("R3 a zero", rc, '0);
        apply(-1, 0, rc, rm, rb);
        chk("R3 b zero", rm, '0);
    endtask

    task automatic t_commute;
        logic [W2-1:0] rc1, rm1, rb1, rc2, rm2, rb2;
        for (int k = -16; k < 16; k += 3) begin
            apply(k, 7 - k, rc1, rm1, rb1);
            apply(7 - k, k, rc2, rm2, rb2);
            chk("R7 conv", rc2, rc1);
            chk("R7 mod", rm2, rm1);
        end
    endtask

    task automatic t_hold;
        logic [W2-1:0] rc, rm, rb;
        apply(7, -3, rc, rm, rb);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R10 conv hold", p_conv, exp_prod(7, -3));
            chk("R10 mod hold", p_mod, exp_prod(7, -3));
        end
        rst = 1'b1;
        @(negedge clk);
        chk("R5 mid-run reset conv", p_conv, '0);
        chk("R5 mid-run reset mod", p_mod, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", p_mod, exp_prod(7, -3));
    endtask

    initial begin
        t_reset();
        t_exhaustive();
        t_corners();
        t_commute();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule